// File: doc/BRIEF.md
# Indexed Register Access Window

This block gives a byte-wide host register port access to a 16-bit internal configuration address space through two host offsets: an index register at 0xF4 and a data register at 0xF5. The target address is not written in one step. The host first writes a key value (0x9F) to the index register, which arms the window. The next write to the data register is taken as the high address byte. The index write after that supplies the low address byte and completes the selection. From then on, data-register writes store a byte at the selected target and data-register reads return it. Software can therefore do read-modify-write updates on individual configuration bytes, such as setting a control nibble or one output-level bit.

The back-end store holds 2^STORE_AW bytes and decodes only the low STORE_AW bits of the selected address, so higher addresses alias onto it. The host port uses plain pulses rather than a handshake: every access finishes in one cycle and there is no back-pressure. A read strobe always produces a registered result on the next cycle, qualified by a one-cycle valid pulse.

Top module: `idx_window_top`

## Requirements
- R1: After reset the window is not armed, the selected address is 0x0000, every stored byte is 0x00, `host_rdata` is 0x00 and `host_rvalid` is low.
- R2: Writing 0x9F to offset 0xF4 arms the window. While the window is armed, a write to offset 0xF5 is captured as the high address byte and is not stored to any target.
- R3: After the high byte is captured, the next write to offset 0xF4 is taken as the low address byte for any value, 0x9F included. The selected address becomes {high, low}, the window returns to normal operation, and a read of 0xF4 then returns the selected low byte.
- R4: With the window not armed, a write to 0xF5 stores the byte at the selected address. A read strobe on 0xF5 returns that target's byte on `host_rdata` in the cycle after the strobe, and `host_rvalid` is high in exactly that cycle.
- R5: Index writes of a value other than 0x9F are ignored when the window is idle, and also while it is armed but has not yet captured a high byte. A 0x9F written in the armed state keeps the window armed.
- R6: The selected address does not change after a data read or a data write. Repeated accesses all hit the same target.
- R7: Until the low byte completes a selection, the previous target stays in effect: data reads during the sequence return the old target's byte.
- R8: The store decodes only the low STORE_AW bits of the selected address. Two addresses that agree in those bits reach the same byte.
- R9: Writes to offsets other than 0xF4 and 0xF5 have no effect, even the key value 0x9F. Reads of those offsets return 0x00.
- R10: A read-modify-write through the window updates only the intended bits. The other bits of that byte and the other targets keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host register offset of the access |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, registered, valid in the cycle after `host_rd` |
| host_rvalid | output | 1 | High for one cycle when `host_rdata` carries a fresh read result |

## Verification
The bench builds the block with STORE_AW = 8, a 256-byte store. With that setting, two targets that lie far apart in the address space, 0x104F and 0xFE3F, fall on separate bytes, while 0x204F and 0x2010 alias onto 0x104F and 0x0010 respectively. Aliasing and independence can both be observed at the ports. ADDR_W stays at 16, so the keyed sequence sets a full high byte. The key stays at 0x9F, which allows a low byte equal to the key to be tested.

// File: rtl/idx_window_pkg.sv
package idx_window_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_ARMED = 2'd1,
    WIN_HIGH  = 2'd2
  } win_state_t;
endpackage

// File: rtl/idx_window_seq.sv
module idx_window_seq
  import idx_window_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [7:0]  ARM_KEY = 8'h9F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              dat_we,
  input  logic [7:0]        wdata,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              consume,
  output win_state_t        state
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0] hi_q;

  // a data write is swallowed only while the window waits for its high byte
  assign consume = (state == WIN_ARMED) && dat_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= WIN_IDLE;
      hi_q     <= '0;
      sel_addr <= '0;
    end else begin
      unique case (state)
        WIN_IDLE: begin
          if (idx_we && (wdata == ARM_KEY)) state <= WIN_ARMED;
        end
        WIN_ARMED: begin
          if (dat_we) begin
            hi_q  <= wdata[HI_W-1:0];
            state <= WIN_HIGH;
          end
        end
        WIN_HIGH: begin
          if (idx_we) begin
            sel_addr <= {hi_q, wdata};
            state    <= WIN_IDLE;
          end
        end
        default: state <= WIN_IDLE;
      endcase
    end
  end

  p_ignore_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WIN_IDLE && idx_we && wdata != ARM_KEY) |=> (state == WIN_IDLE));

  p_armed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WIN_ARMED && idx_we) |=> (state == WIN_ARMED));

  p_hold_midseq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != WIN_HIGH) |=> $stable(sel_addr));

  p_noinc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_we) |=> $stable(sel_addr));

  p_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WIN_HIGH && idx_we) |=> (state == WIN_IDLE && sel_addr[7:0] == $past(wdata)));
endmodule

// File: rtl/idx_window_store.sv
module idx_window_store #(
  parameter int STORE_AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [STORE_AW-1:0] addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata
);
  localparam int DEPTH = 1 << STORE_AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

  p_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((addr != $past(addr)) || (rdata == $past(wdata))));
endmodule

// File: rtl/idx_window_top.sv
module idx_window_top
  import idx_window_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         STORE_AW = 6,
  parameter logic [7:0] IDX_OFS  = 8'hF4,
  parameter logic [7:0] DAT_OFS  = 8'hF5,
  parameter logic [7:0] ARM_KEY  = 8'h9F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  output logic       host_rvalid
);
  logic              idx_we, dat_we, consume, store_we;
  logic [ADDR_W-1:0] sel_addr;
  logic [7:0]        store_rdata;
  win_state_t        state;
  logic              unused_sel;

  assign idx_we   = host_wr && (host_addr == IDX_OFS);
  assign dat_we   = host_wr && (host_addr == DAT_OFS);
  assign store_we = dat_we && !consume;
  assign unused_sel = ^sel_addr;

  idx_window_seq #(.ADDR_W(ADDR_W), .ARM_KEY(ARM_KEY)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_we   (idx_we),
    .dat_we   (dat_we),
    .wdata    (host_wdata),
    .sel_addr (sel_addr),
    .consume  (consume),
    .state    (state)
  );

  idx_window_store #(.STORE_AW(STORE_AW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_we),
    .addr  (sel_addr[STORE_AW-1:0]),
    .wdata (host_wdata),
    .rdata (store_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= 8'h00;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) begin
        if (host_addr == DAT_OFS)      host_rdata <= store_rdata;
        else if (host_addr == IDX_OFS) host_rdata <= sel_addr[7:0];
        else                           host_rdata <= 8'h00;
      end
    end
  end

  p_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  p_rvalid_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid);

  p_hi_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WIN_ARMED && dat_we) |=> (state == WIN_HIGH));

  p_other_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr != DAT_OFS && host_addr != IDX_OFS) |=> (host_rdata == 8'h00));
endmodule

// File: tb/idx_window_top_tb.sv
module idx_window_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_addr = 8'h00;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic       host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       host_rvalid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [7:0] IDX = 8'hF4;
  localparam logic [7:0] DAT = 8'hF5;
  localparam logic [7:0] KEY = 8'h9F;

  always #4 clk = ~clk;

  idx_window_top #(.STORE_AW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [7:0] val);
    @(negedge clk);
    host_addr = ofs; host_wdata = val; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ofs, output logic [7:0] val);
    @(negedge clk);
    host_addr = ofs; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    val = host_rdata;
    check(host_rvalid === 1'b1, "R4 rvalid", int'(host_rvalid), 1);
    @(negedge clk);
    check(host_rvalid === 1'b0, "R4 rvalid pulse", int'(host_rvalid), 0);
  endtask

  task automatic expect_rd(input logic [7:0] ofs, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(ofs, v);
    check(v === exp, req, int'(v), int'(exp));
  endtask

  task automatic select(input logic [15:0] a);
    wr(IDX, KEY);
    wr(DAT, a[15:8]);
    wr(IDX, a[7:0]);
  endtask

  task automatic t_reset();
    check(host_rdata === 8'h00, "R1 rdata", int'(host_rdata), 0);
    check(host_rvalid === 1'b0, "R1 rvalid", int'(host_rvalid), 0);
    expect_rd(IDX, 8'h00, "R1 index");
    expect_rd(DAT, 8'h00, "R1 data");
    wr(DAT, 8'h3C);
    expect_rd(DAT, 8'h3C, "R1 selected zero");
    wr(DAT, 8'h00);
  endtask

  task automatic t_select();
    select(16'h06A0);
    expect_rd(IDX, 8'hA0, "R3 low byte");
    expect_rd(DAT, 8'h00, "R4 fresh target");
    wr(DAT, 8'h74);
    expect_rd(DAT, 8'h74, "R4 write read");
    select(16'h0000);
    expect_rd(DAT, 8'h00, "R2 high byte not stored at old target");
    select(16'h06A0);
    expect_rd(DAT, 8'h74, "R2 hi byte 00 not stored");
  endtask

  task automatic t_ignore();
    wr(IDX, 8'h55);
    wr(DAT, 8'h11);
    expect_rd(DAT, 8'h11, "R5 idle index write ignored");
    expect_rd(IDX, 8'hA0, "R5 address kept");
    wr(IDX, KEY);
    wr(IDX, 8'h33);
    wr(IDX, KEY);
    wr(DAT, 8'h12);
    wr(IDX, 8'h34);
    expect_rd(IDX, 8'h34, "R5 armed index write ignored");
    wr(DAT, 8'h77);
    expect_rd(DAT, 8'h77, "R5 target 1234");
    select(16'h06A0);
    expect_rd(DAT, 8'h11, "R5 old target intact");
  endtask

  task automatic t_midseq();
    select(16'h0010);
    wr(DAT, 8'hAB);
    wr(IDX, KEY);
    expect_rd(DAT, 8'hAB, "R7 armed read old target");
    wr(DAT, 8'h20);
    expect_rd(DAT, 8'hAB, "R7 high captured read old target");
    expect_rd(IDX, 8'h10, "R7 index unchanged");
    wr(IDX, 8'h10);
    expect_rd(DAT, 8'hAB, "R8 alias 2010 onto 0010");
  endtask

  task automatic t_noinc();
    select(16'h0040);
    wr(DAT, 8'h01);
    wr(DAT, 8'h02);
    expect_rd(DAT, 8'h02, "R6 second write same target");
    expect_rd(DAT, 8'h02, "R6 repeat read");
    expect_rd(IDX, 8'h40, "R6 index");
    select(16'h0041);
    expect_rd(DAT, 8'h00, "R6 next byte untouched");
  endtask

  task automatic t_key_low();
    wr(IDX, KEY);
    wr(DAT, 8'h03);
    wr(IDX, KEY);
    expect_rd(IDX, KEY, "R3 key as low byte");
    wr(DAT, 8'h44);
    expect_rd(DAT, 8'h44, "R3 not re-armed");
    wr(DAT, 8'h45);
    expect_rd(DAT, 8'h45, "R3 data stored");
  endtask

  task automatic t_rmw();
    logic [7:0] v;
    select(16'h104F);
    wr(DAT, 8'hA7);
    rd(DAT, v);
    wr(DAT, (v & 8'hF0) | 8'h01);
    expect_rd(DAT, 8'hA1, "R10 nibble set");
    select(16'hFE3F);
    wr(DAT, 8'h5E);
    rd(DAT, v);
    wr(DAT, (v & 8'hFE) | 8'h01);
    expect_rd(DAT, 8'h5F, "R10 bit0 set");
    select(16'h104F);
    expect_rd(DAT, 8'hA1, "R10 other target intact");
    select(16'h204F);
    expect_rd(DAT, 8'hA1, "R8 alias 204F");
  endtask

  task automatic t_other();
    select(16'h0050);
    wr(8'h70, KEY);
    expect_rd(8'h70, 8'h00, "R9 other offset reads zero");
    wr(DAT, 8'h99);
    expect_rd(DAT, 8'h99, "R9 key at other offset did not arm");
    expect_rd(IDX, 8'h50, "R9 address unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_ignore();
    t_midseq();
    t_noinc();
    t_key_low();
    t_rmw();
    t_other();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule